// File: doc/BRIEF.md
# Two-Level Masked Interrupt Priority Arbiter

This block sits between a set of interrupt sources and a CPU core. It takes several maskable request lines and one non-maskable request. Each maskable source has an enable bit, a one-bit priority level and a type bit that selects edge or level behaviour. From these it picks a single winner. It then applies the CPU's two mask bits and a mode bit, and presents the accepted source number and its vector number on registered outputs.

The CPU mask bits are called I and UI, and the mode bit is called UE. With UE=1, the I bit alone gates every maskable source. With UE=0, the I and UI bits together with the per-source level give three masking levels: all sources open, only level-1 sources open, or only the non-maskable request open.

Requests that lose arbitration or are masked are not dropped. A level-type source stays pending while its line is high. An edge-type source, and the non-maskable request, stay latched until the CPU acknowledges them.

Top module: `irq_arb`

## Requirements
- R1: After reset, and whenever no request is accepted, irq_o=0, id_o=0 and vec_o=0.
- R2: A maskable source whose en_i bit is 0 is never accepted.
- R3: Among accepted candidates, any source with lvl_i=1 beats every source with lvl_i=0, regardless of index.
- R4: Among candidates of equal level, the lowest index wins (index 0 ranks highest).
- R5: A pending non-maskable request wins over every maskable source for all values of I, UI and UE. It is reported as id_o=8 (the source count) and vec_o=7.
- R6: With ue_i=1, i_mask_i=1 blocks all maskable sources of either level, and i_mask_i=0 opens them.
- R7: With ue_i=0, i_mask_i=1 and ui_mask_i=0, only level-1 sources are accepted; level-0 sources stay pending.
- R8: With ue_i=0, i_mask_i=1 and ui_mask_i=1, no maskable source is accepted.
- R9: A masked or losing request remains pending, and it is accepted once the sources that beat it are gone.
- R10: Where edge_sel_i bit n is 1, a rising edge on req_i bit n latches a pending flag. That flag is cleared only by ack_i while id_o=n. Where edge_sel_i bit n is 0, the source follows its line and ack_i has no effect on it.
- R11: For maskable source n, vec_o = 12 + n.
- R12: A change on req_i reaches the outputs at the second rising clock edge. Output changes caused by a change of mask or enable appear at the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Maskable request lines |
| edge_sel_i | input | 8 | Per-source type: 1 = edge latched, 0 = level |
| en_i | input | 8 | Per-source enable |
| lvl_i | input | 8 | Per-source priority level |
| nmi_i | input | 1 | Non-maskable request, rising-edge latched |
| ue_i | input | 1 | Mask mode select |
| i_mask_i | input | 1 | CPU interrupt mask bit I |
| ui_mask_i | input | 1 | CPU user mask bit UI |
| ack_i | input | 1 | Acknowledge of the presented source |
| irq_o | output | 1 | A request is accepted |
| id_o | output | 4 | Accepted source number (8 = non-maskable) |
| vec_o | output | 8 | Vector number of accepted source |

## Verification
Two-source request sets are applied first with equal levels and then with mixed levels. This separates the index rule from the level rule. The same wide request pattern is then run through every combination of I, UI and UE, and the result shows which of the three masking tiers is in force. Finally, three cases check how pending state is kept: a masked non-maskable request, a single-cycle pulse on an edge-type source, and an acknowledge aimed at a level-type source. These show whether the flag survives or clears as required.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Mask tier rule: returns 1 when a source of level lvl may pass the CPU masks
  function automatic logic mask_open(input logic ue, input logic i_m,
                                     input logic ui_m, input logic lvl);
    if (!i_m) return 1'b1;
    if (ue) return 1'b0;
    return lvl & ~ui_m;
  endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic edge_i,
  input  logic clr_i,
  output logic pend_o
);
  logic req_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q <= req_i;
      if (edge_i) pend_q <= (pend_q & ~clr_i) | (req_i & ~req_q);
      else        pend_q <= req_i;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] lvl_i,
  input  logic             ue_i,
  input  logic             i_mask_i,
  input  logic             ui_mask_i,
  output logic [N_SRC-1:0] elig_o
);
  import irq_arb_pkg::*;

  for (genvar g = 0; g < N_SRC; g++) begin : g_gate
    assign elig_o[g] = pend_i[g] & en_i[g] & mask_open(ue_i, i_mask_i, ui_mask_i, lvl_i[g]);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC    = 8,
  parameter int ID_W     = 4,
  parameter int VEC_W    = 8,
  parameter int NMI_VEC  = 7,
  parameter int VEC_BASE = 12
) (
  input  logic             nmi_pend_i,
  input  logic [N_SRC-1:0] elig_i,
  input  logic [N_SRC-1:0] lvl_i,
  output logic             vld_o,
  output logic [ID_W-1:0]  id_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N_SRC-1:0] hi, cand;

  always_comb begin
    hi    = elig_i & lvl_i;
    cand  = (|hi) ? hi : elig_i;
    vld_o = 1'b0;
    id_o  = '0;
    vec_o = '0;
    // descending scan: lowest index ends up winning
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (cand[k]) begin
        vld_o = 1'b1;
        id_o  = ID_W'(k);
        vec_o = VEC_W'(VEC_BASE + k);
      end
    end
    if (nmi_pend_i) begin
      vld_o = 1'b1;
      id_o  = ID_W'(N_SRC);
      vec_o = VEC_W'(NMI_VEC);
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int NMI_VEC  = 7,
  parameter int VEC_BASE = 12,
  localparam int ID_W    = $clog2(N_SRC) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] edge_sel_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] lvl_i,
  input  logic             nmi_i,
  input  logic             ue_i,
  input  logic             i_mask_i,
  input  logic             ui_mask_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [ID_W-1:0]  id_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N_SRC-1:0] pend, clr, elig;
  logic             nmi_pend, nmi_clr;
  logic             vld_d;
  logic [ID_W-1:0]  id_d;
  logic [VEC_W-1:0] vec_d;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign clr[g] = ack_i & irq_o & (id_o == ID_W'(g));
    irq_src_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_i[g]),
      .edge_i (edge_sel_i[g]),
      .clr_i  (clr[g]),
      .pend_o (pend[g])
    );
  end

  assign nmi_clr = ack_i & irq_o & (id_o == ID_W'(N_SRC));

  irq_src_cell u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (nmi_i),
    .edge_i (1'b1),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend)
  );

  irq_gate #(.N_SRC(N_SRC)) u_gate (
    .pend_i    (pend),
    .en_i      (en_i),
    .lvl_i     (lvl_i),
    .ue_i      (ue_i),
    .i_mask_i  (i_mask_i),
    .ui_mask_i (ui_mask_i),
    .elig_o    (elig)
  );

  irq_pick #(
    .N_SRC(N_SRC), .ID_W(ID_W), .VEC_W(VEC_W),
    .NMI_VEC(NMI_VEC), .VEC_BASE(VEC_BASE)
  ) u_pick (
    .nmi_pend_i (nmi_pend),
    .elig_i     (elig),
    .lvl_i      (lvl_i),
    .vld_o      (vld_d),
    .id_o       (id_d),
    .vec_o      (vec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      id_o  <= '0;
      vec_o <= '0;
    end else begin
      irq_o <= vld_d;
      id_o  <= id_d;
      vec_o <= vec_d;
    end
  end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int NMI_VEC  = 7,
  parameter int VEC_BASE = 12,
  localparam int ID_W    = $clog2(N_SRC) + 1,
  localparam int SEL_W   = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] en_i,
  input logic [N_SRC-1:0] lvl_i,
  input logic             ue_i,
  input logic             i_mask_i,
  input logic             ui_mask_i,
  input logic             irq_o,
  input logic [ID_W-1:0]  id_o,
  input logic [VEC_W-1:0] vec_o
);
  localparam logic [ID_W-1:0] NMI_ID = ID_W'(N_SRC);

  logic [N_SRC-1:0] en_q, lvl_q;
  logic             mskbl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      lvl_q <= '0;
    end else begin
      en_q  <= en_i;
      lvl_q <= lvl_i;
    end
  end

  assign mskbl = irq_o && (id_o < NMI_ID);

  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (id_o == '0 && vec_o == '0));

  // R2
  enabled_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mskbl |-> en_q[id_o[SEL_W-1:0]]);

  // R5
  nmi_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && id_o == NMI_ID) |-> vec_o == VEC_W'(NMI_VEC));

  // R6
  ue_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mskbl && $past(ue_i)) |-> !$past(i_mask_i));

  // R7
  mid_tier_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mskbl && !$past(ue_i) && $past(i_mask_i)) |-> (lvl_q[id_o[SEL_W-1:0]] && !$past(ui_mask_i)));

  // R8
  full_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mskbl |-> !(!$past(ue_i) && $past(i_mask_i) && $past(ui_mask_i)));

  // R11
  vec_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mskbl |-> vec_o == VEC_W'(VEC_BASE) + VEC_W'(id_o));
endmodule

bind irq_arb irq_arb_chk #(
  .N_SRC(N_SRC), .VEC_W(VEC_W), .NMI_VEC(NMI_VEC), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .lvl_i     (lvl_i),
  .ue_i      (ue_i),
  .i_mask_i  (i_mask_i),
  .ui_mask_i (ui_mask_i),
  .irq_o     (irq_o),
  .id_o      (id_o),
  .vec_o     (vec_o)
);

// File: tb/sim_irq_arb.sv
module sim_irq_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, eg = '0, en = 8'hFF, lv = '0;
  logic       nmi = 1'b0, ue = 1'b0, im = 1'b0, uim = 1'b0, ack = 1'b0;
  logic       irq;
  logic [3:0] id;
  logic [7:0] vec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic       v;
    logic [3:0] id;
    logic [7:0] vec;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  irq_arb u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .edge_sel_i(eg), .en_i(en),
    .lvl_i(lv), .nmi_i(nmi), .ue_i(ue), .i_mask_i(im), .ui_mask_i(uim),
    .ack_i(ack), .irq_o(irq), .id_o(id), .vec_o(vec)
  );

  // monitor: compare queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (irq !== e.v || id !== e.id || vec !== e.vec) begin
          failures++;
          $display("FAIL %s: actual irq=%0b id=%0d vec=%0d expected irq=%0b id=%0d vec=%0d",
                   e.tag, irq, id, vec, e.v, e.id, e.vec);
        end
      end
    end
  end

  task automatic push(input logic v, input logic [3:0] i, input logic [7:0] vv, input string t);
    exp_t e;
    e.v = v; e.id = i; e.vec = vv; e.tag = t;
    q.push_back(e);
  endtask

  // inputs already set at a falling edge; wait two rising edges, then expect
  task automatic chk(input logic v, input logic [3:0] i, input logic [7:0] vv, input string t);
    @(posedge clk); @(posedge clk);
    push(v, i, vv, t);
    @(negedge clk);
  endtask

  task automatic ack_pulse();
    @(negedge clk); ack = 1'b1;
    @(posedge clk);
    @(negedge clk); ack = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    push(1'b0, 4'd0, 8'd0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 request-path latency
    req = 8'h02;
    @(posedge clk); push(1'b0, 4'd0, 8'd0, "R12 one edge");
    @(negedge clk);
    @(posedge clk); push(1'b1, 4'd1, 8'd13, "R12 R11 two edges");
    @(negedge clk);

    @(negedge clk); req = 8'h24;
    chk(1'b1, 4'd2, 8'd14, "R4 lowest index");
    @(negedge clk); lv = 8'h20;
    chk(1'b1, 4'd5, 8'd17, "R3 level beats index");
    @(negedge clk); lv = 8'h00; en = 8'hFB;
    chk(1'b1, 4'd5, 8'd17, "R2 disabled source skipped");
    @(negedge clk); en = 8'h00;
    chk(1'b0, 4'd0, 8'd0, "R2 all disabled");

    // R5 non-maskable under full mask
    @(negedge clk); en = 8'hFF; req = 8'h01; im = 1'b1; uim = 1'b1; nmi = 1'b1;
    chk(1'b1, 4'd8, 8'd7, "R5 nmi full mask");
    ack_pulse();
    push(1'b0, 4'd0, 8'd0, "R5 R8 nmi acked");
    @(negedge clk);
    @(negedge clk); nmi = 1'b0; req = 8'hFF; lv = 8'hF0;
    chk(1'b0, 4'd0, 8'd0, "R8 full mask");

    @(negedge clk); uim = 1'b0; req = 8'h4F; lv = 8'h40;
    chk(1'b1, 4'd6, 8'd18, "R7 level1 passes");
    @(negedge clk); lv = 8'h00;
    chk(1'b0, 4'd0, 8'd0, "R7 level0 held");

    @(negedge clk); ue = 1'b1; lv = 8'h40;
    chk(1'b0, 4'd0, 8'd0, "R6 I blocks level1");
    @(negedge clk); im = 1'b0;
    chk(1'b1, 4'd6, 8'd18, "R6 I clear opens");
    @(negedge clk); lv = 8'h00;
    chk(1'b1, 4'd0, 8'd12, "R6 R11 level0 open");

    @(negedge clk); ue = 1'b0; req = 8'h21;
    chk(1'b1, 4'd0, 8'd12, "R9 winner");
    @(negedge clk); req = 8'h20;
    chk(1'b1, 4'd5, 8'd17, "R9 loser kept");

    // R10 edge-type latch and acknowledge
    @(negedge clk); req = 8'h00; eg = 8'h08;
    chk(1'b0, 4'd0, 8'd0, "R10 idle");
    @(negedge clk); req = 8'h08;
    chk(1'b1, 4'd3, 8'd15, "R10 edge latched");
    @(negedge clk); req = 8'h00;
    chk(1'b1, 4'd3, 8'd15, "R10 held after line drop");
    ack_pulse();
    push(1'b0, 4'd0, 8'd0, "R10 edge acked");
    @(negedge clk);
    @(negedge clk); eg = 8'h00; req = 8'h10;
    chk(1'b1, 4'd4, 8'd16, "R10 level source");
    ack_pulse();
    push(1'b1, 4'd4, 8'd16, "R10 level ignores ack");
    @(negedge clk);

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule